// File: doc/BRIEF.md
# Transmit Completion Status Stack

This block keeps a short last-in, first-out stack of per-packet transmit completion status bytes. The transmit engine pushes one entry when a packet ends with a condition worth reporting. It raises a flag for each of three causes: excessive jabber, FIFO underrun and collision limit reached. The host sees the top entry on a byte-wide read port. It removes that entry by writing to the same register. The value written does not matter.

While at least one entry is held, the block asserts a transmit-complete flag. Popped entries are ORed into an accumulated-error byte. This byte tells the host whether the transmitter must be reset before transmission is enabled again. A transmitter-reset input clears the accumulated byte.

Top module: `tx_status_stack`

## Requirements
- R1: A pushed entry is the byte {1, 0, jabber, underrun, collision-limit, 0, 0, 0}. Bit 7 is a completion marker, bit 5 is jabber (0x20), bit 4 is underrun (0x10) and bit 3 is collision limit (0x08). A valid entry is therefore never zero.
- R2: `st_rdata` shows the most recently pushed entry that is still held, without removing it. It reads 0x00 when the stack is empty.
- R3: A cycle with `st_wr` high and a non-empty stack removes the top entry. Entries leave in the reverse order of their pushes.
- R4: `st_wr` on an empty stack changes nothing: `st_rdata` stays 0x00, `tx_complete` stays low and `err_accum` keeps its value.
- R5: A push into a full stack (DEPTH entries) discards the oldest entry and keeps the DEPTH newest.
- R6: `tx_complete` is high exactly while the stack holds at least one entry.
- R7: `err_accum` takes the OR of every entry popped since the last `tx_rst`. `tx_rst` clears it, but an entry popped in the same cycle as `tx_rst` is still recorded.
- R8: `need_reset` is high while `err_accum` has bit 5 (jabber) or bit 4 (underrun) set.
- R9: A push and a pop in the same cycle first remove the top entry and then push the new one. On a non-empty stack the top is therefore replaced. On an empty stack the stack holds only the new entry.
- R10: After reset the stack is empty and `err_accum` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push | input | 1 | Push one status entry |
| push_jab | input | 1 | Jabber flag for the pushed entry |
| push_und | input | 1 | Underrun flag for the pushed entry |
| push_col | input | 1 | Collision-limit flag for the pushed entry |
| st_wr | input | 1 | Host write to the status register (pops the top entry) |
| st_rdata | output | 8 | Top entry, 0x00 when empty |
| tx_complete | output | 1 | High while any entry is held |
| tx_rst | input | 1 | Transmitter reset, clears the accumulated error byte |
| err_accum | output | 8 | OR of entries popped since the last transmitter reset |
| need_reset | output | 1 | Accumulated jabber or underrun |

## Verification
The bench builds the block with its default depth of 4 entries. This small depth lets random push and pop traffic fill the stack often. Overflow with oldest-entry discard, pushes and pops in the same cycle at full and at empty, and pops on an empty stack all occur many times in a few thousand cycles. Directed sequences then pin down the exact overflow order and the interplay between clearing `err_accum` and popping in the same cycle.

// File: rtl/tx_status_stack.sv
module tx_status_stack #(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  logic       push_jab,
  input  logic       push_und,
  input  logic       push_col,
  input  logic       st_wr,
  output logic [7:0] st_rdata,
  output logic       tx_complete,
  input  logic       tx_rst,
  output logic [7:0] err_accum,
  output logic       need_reset
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [7:0]    stk [DEPTH];
  logic [CW-1:0] cnt;
  logic          pop;
  logic [CW-1:0] cnt_p;
  logic [CW-1:0] top_c;
  logic [IW-1:0] top_i;
  logic [IW-1:0] wr_i;
  logic [7:0]    new_e;
  logic [7:0]    popped;
  logic          full_p;

  assign pop         = st_wr && (cnt != '0);
  assign cnt_p       = cnt - CW'(pop);
  assign top_c       = cnt - CW'(1);
  assign top_i       = top_c[IW-1:0];
  assign wr_i        = cnt_p[IW-1:0];
  assign full_p      = (cnt_p == CW'(DEPTH));
  assign new_e       = {1'b1, 1'b0, push_jab, push_und, push_col, 3'b000};
  assign st_rdata    = (cnt != '0) ? stk[top_i] : 8'h00;
  assign popped      = pop ? stk[top_i] : 8'h00;
  assign tx_complete = (cnt != '0);
  assign need_reset  = err_accum[5] | err_accum[4];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      err_accum <= 8'h00;
      for (int i = 0; i < DEPTH; i++) stk[i] <= 8'h00;
    end else begin
      err_accum <= (tx_rst ? 8'h00 : err_accum) | popped;
      if (push) begin
        if (full_p) begin
          for (int i = 0; i < DEPTH - 1; i++) stk[i] <= stk[i+1];
          stk[DEPTH-1] <= new_e;
          cnt <= cnt_p;
        end else begin
          stk[wr_i] <= new_e;
          cnt <= cnt_p + CW'(1);
        end
      end else begin
        cnt <= cnt_p;
      end
    end
  end
endmodule

module tx_status_stack_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       push,
  input logic       push_jab,
  input logic       push_und,
  input logic       push_col,
  input logic       st_wr,
  input logic [7:0] st_rdata,
  input logic       tx_complete,
  input logic       tx_rst,
  input logic [7:0] err_accum,
  input logic       need_reset
);
  // R1
  entry_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> st_rdata == {1'b1, 1'b0, $past(push_jab), $past(push_und), $past(push_col), 3'b000});
  // R6
  push_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> tx_complete);
  // R4
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && !push && !tx_rst && !tx_complete) |=> (!tx_complete && st_rdata == 8'h00 && $stable(err_accum)));
  // R7
  accum_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_rst && !st_wr) |=> err_accum == 8'h00);
  // R7
  accum_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_rst && !st_wr) |=> $stable(err_accum));
  // R8
  need_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && tx_complete && (st_rdata[5] || st_rdata[4])) |=> need_reset);
  // R2
  hold_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!push && !st_wr) |=> $stable(st_rdata));
endmodule

bind tx_status_stack tx_status_stack_chk u_chk (.*);

// File: tb/tb_tx_status_stack.sv
module tb_tx_status_stack;
  localparam int DEPTH = 4;
  logic clk = 1'b0;
  logic rst_n, push, push_jab, push_und, push_col, st_wr, tx_rst;
  logic [7:0] st_rdata, err_accum;
  logic tx_complete, need_reset;

  int checks = 0;
  int errors = 0;
  logic [7:0] mstk [DEPTH];
  int mcnt;
  logic [7:0] macc;

  always #10 clk = ~clk;

  tx_status_stack #(.DEPTH(DEPTH)) dut (.*);

  function automatic logic [7:0] entry(input logic j, input logic u, input logic c);
    return {1'b1, 1'b0, j, u, c, 3'b000};
  endfunction

  function automatic logic [7:0] top_exp();
    return (mcnt > 0) ? mstk[mcnt-1] : 8'h00;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    check({req, " rdata"}, st_rdata, top_exp());
    check("R6 tx_complete", {7'd0, tx_complete}, {7'd0, mcnt > 0});
    check("R7 err_accum", err_accum, macc);
    check("R8 need_reset", {7'd0, need_reset}, {7'd0, macc[5] | macc[4]});
  endtask

  task automatic step(input logic p, input logic j, input logic u, input logic c,
                      input logic w, input logic r, input string req);
    logic [7:0] popped;
    push = p; push_jab = j; push_und = u; push_col = c; st_wr = w; tx_rst = r;
    @(posedge clk);
    popped = 8'h00;
    if (w && mcnt > 0) begin
      popped = mstk[mcnt-1];
      mcnt--;
    end
    macc = (r ? 8'h00 : macc) | popped;
    if (p) begin
      if (mcnt == DEPTH) begin
        for (int i = 0; i < DEPTH - 1; i++) mstk[i] = mstk[i+1];
        mstk[DEPTH-1] = entry(j, u, c);
      end else begin
        mstk[mcnt] = entry(j, u, c);
        mcnt++;
      end
    end
    #5;
    push = 0; st_wr = 0; tx_rst = 0;
    check_all(req);
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed_1234);
    rst_n = 0; push = 0; push_jab = 0; push_und = 0; push_col = 0; st_wr = 0; tx_rst = 0;
    mcnt = 0; macc = 8'h00;
    repeat (3) @(posedge clk);
    #5; rst_n = 1;
    // R10
    check("R10 reset rdata", st_rdata, 8'h00);
    check("R10 reset accum", err_accum, 8'h00);
    check("R10 reset flag", {7'd0, tx_complete}, 8'h00);

    step(1, 1, 0, 0, 0, 0, "R1");
    check("R1 jabber entry", st_rdata, 8'hA0);
    step(0, 0, 0, 0, 0, 0, "R2 reread");
    step(0, 0, 0, 0, 0, 0, "R2 reread");
    check("R2 top kept", st_rdata, 8'hA0);
    step(1, 0, 1, 0, 0, 0, "R1");
    check("R1 underrun entry", st_rdata, 8'h90);
    step(1, 0, 0, 1, 0, 0, "R1");
    check("R1 collision entry", st_rdata, 8'h88);
    step(1, 0, 0, 0, 0, 0, "R1");
    step(1, 1, 1, 1, 0, 0, "R5");
    check("R5 newest on top", st_rdata, 8'hB8);
    step(0, 0, 0, 0, 1, 0, "R3");
    check("R3 pop order 1", st_rdata, 8'h80);
    step(0, 0, 0, 0, 1, 0, "R3");
    check("R3 pop order 2", st_rdata, 8'h88);
    step(0, 0, 0, 0, 1, 0, "R3");
    check("R5 oldest dropped", st_rdata, 8'h90);
    step(0, 0, 0, 0, 1, 0, "R3");
    check("R3 empty after pops", st_rdata, 8'h00);
    check("R7 accum or", err_accum, 8'hB8);
    check("R8 need reset", {7'd0, need_reset}, 8'h01);
    step(0, 0, 0, 0, 1, 0, "R4");
    check("R4 empty pop accum", err_accum, 8'hB8);
    step(0, 0, 0, 0, 0, 1, "R7");
    check("R7 cleared", err_accum, 8'h00);
    step(1, 0, 0, 1, 0, 0, "R9");
    step(1, 1, 0, 0, 1, 1, "R9");
    check("R9 top replaced", st_rdata, 8'hA0);
    check("R7 pop with clear", err_accum, 8'h88);
    step(0, 0, 0, 0, 1, 0, "R9");
    check("R9 single entry", st_rdata, 8'h00);
    step(1, 0, 1, 0, 1, 0, "R9");
    check("R9 empty push pop", st_rdata, 8'h90);

    for (int k = 0; k < 3000; k++) begin
      logic [31:0] rv;
      rv = $urandom;
      step(rv[0], rv[1], rv[2], rv[3], rv[4] & rv[5], rv[6] & rv[7] & rv[8], "R2 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule